// File: doc/BRIEF.md
# Packed Horizontal Subtractor (16/32-bit elements)

This block takes two 256-bit vector operands and produces, for every adjacent pair of signed elements, the difference of the pair. The element size is 16 or 32 bits and is chosen per operation. The operands are treated as two independent 128-bit lanes. Within each lane, the lower half of the result is filled from the pairs of operand A and the upper half from the pairs of operand B. Differences wrap modulo the element width and never saturate.

Three width modes are supported. The full mode computes both lanes. The zeroing narrow mode computes the low lane and clears the high lane. The merging narrow mode computes the low lane and leaves the high lane of the result register as it was. In that mode the caller supplies the old destination contents as operand A.

Operands are captured on `in_valid`. The packed result is presented one clock later, together with `out_valid`. The block is intended as a single-cycle execution slice inside a vector pipeline.

Top module: `vec_hsub_unit`

## Requirements
- R1: Each result element is the lower-addressed element of its source pair minus the higher-addressed element of that pair.
- R2: With `elem_size` = 0 (16-bit), result words 0..3 of a lane (word j at lane bits 16j+15:16j) come from operand A pairs (words 2j, 2j+1), and words 4..7 come from operand B pairs in the same order.
- R3: With `elem_size` = 1 (32-bit), result doublewords 0..1 of a lane come from operand A pairs (dwords 2j, 2j+1), and doublewords 2..3 come from operand B pairs.
- R4: With `mode` = 2'b10, result bits 255:128 are computed from bits 255:128 of both operands, independently of the low lane.
- R5: With `mode` = 2'b01, result bits 255:128 are written as zero.
- R6: With `mode` = 2'b00, result bits 255:128 keep the value they held before the operation.
- R7: Differences keep only the low 16 or 32 bits, with no saturation. For example, 0x8000 − 0x0001 gives 0x7FFF, and 0x7FFFFFFF − 0xFFFFFFFF gives 0x80000000.
- R8: `out_valid` rises in the cycle after `in_valid` is sampled high, with the matching result on `result`.
- R9: When `in_valid` is sampled low, `out_valid` is low in the next cycle and `result` keeps its value.
- R10: A synchronous `rst` clears `out_valid` and `result` to zero. It takes priority over a simultaneous `in_valid`.
- R11: `mode` = 2'b11 behaves exactly as the full 256-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| elem_size | input | 1 | 0 = 16-bit elements, 1 = 32-bit elements |
| mode | input | 2 | 00 merge high lane, 01 zero high lane, 10/11 full width |
| src_a | input | 256 | First operand (old destination in merge mode) |
| src_b | input | 256 | Second operand |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 256 | Packed differences |

## Verification
Reset and an operand capture can arrive in the same cycle. The bench raises `rst` while `in_valid` carries a full-width operation. The expected outcome is a cleared result and a low `out_valid`, not the computed differences.

The merging mode is also exercised directly after a full-width load. This shows that a new low-lane write and the retention of the high lane happen in one clock edge.

A behavioural model in the bench tracks the result register on every clock and is compared at each falling edge.

// File: rtl/vec_hsub_pkg.sv
package vec_hsub_pkg;
   typedef enum logic [1:0] {
      HS_KEEP_HI  = 2'b00,
      HS_ZERO_HI  = 2'b01,
      HS_WIDE     = 2'b10,
      HS_WIDE_ALT = 2'b11
   } hs_mode_e;

   typedef enum logic {
      HS_NARROW = 1'b0,
      HS_BROAD  = 1'b1
   } hs_size_e;
endpackage

// File: rtl/vec_hsub_pair.sv
// One wrapping difference: low element minus high element of a pair.
module vec_hsub_pair #(
   parameter int unsigned ELEM_W = 16
) (
   input  logic [2*ELEM_W-1:0] pair_in,
   output logic [ELEM_W-1:0]   diff_out
);
   if (ELEM_W < 2) begin : g_bad_w
      $error("vec_hsub_pair: ELEM_W must be at least 2");
   end

   always_comb begin
      diff_out = pair_in[ELEM_W-1:0] - pair_in[2*ELEM_W-1:ELEM_W];
   end
endmodule

// File: rtl/vec_hsub_pack.sv
// Packs pair differences of one lane for one element width:
// operand A pairs fill the low half, operand B pairs the high half.
module vec_hsub_pack #(
   parameter int unsigned LANE_W = 128,
   parameter int unsigned ELEM_W = 16
) (
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   output logic [LANE_W-1:0] lane_res
);
   localparam int unsigned PAIR_W = 2 * ELEM_W;
   localparam int unsigned NPAIR  = LANE_W / PAIR_W;
   localparam int unsigned HALF_W = LANE_W / 2;

   if (LANE_W % PAIR_W != 0) begin : g_bad_div
      $error("vec_hsub_pack: LANE_W must be a multiple of twice ELEM_W");
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      vec_hsub_pair #(.ELEM_W(ELEM_W)) u_from_a (
         .pair_in  (lane_a[p*PAIR_W +: PAIR_W]),
         .diff_out (lane_res[p*ELEM_W +: ELEM_W])
      );
      vec_hsub_pair #(.ELEM_W(ELEM_W)) u_from_b (
         .pair_in  (lane_b[p*PAIR_W +: PAIR_W]),
         .diff_out (lane_res[HALF_W + p*ELEM_W +: ELEM_W])
      );
   end
endmodule

// File: rtl/vec_hsub_lane.sv
// One lane: both element widths computed in parallel, selected by size.
module vec_hsub_lane #(
   parameter int unsigned LANE_W   = 128,
   parameter int unsigned NARROW_W = 16
) (
   input  logic              size_sel,
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   output logic [LANE_W-1:0] lane_res
);
   import vec_hsub_pkg::*;

   localparam int unsigned BROAD_W = 2 * NARROW_W;

   logic [LANE_W-1:0] res_narrow;
   logic [LANE_W-1:0] res_broad;

   vec_hsub_pack #(.LANE_W(LANE_W), .ELEM_W(NARROW_W)) u_narrow (
      .lane_a   (lane_a),
      .lane_b   (lane_b),
      .lane_res (res_narrow)
   );

   vec_hsub_pack #(.LANE_W(LANE_W), .ELEM_W(BROAD_W)) u_broad (
      .lane_a   (lane_a),
      .lane_b   (lane_b),
      .lane_res (res_broad)
   );

   always_comb begin
      lane_res = (size_sel == HS_BROAD) ? res_broad : res_narrow;
   end
endmodule

// File: rtl/vec_hsub_unit.sv
// Packed horizontal subtractor, two lanes, registered output.
module vec_hsub_unit #(
   parameter int unsigned LANE_W   = 128,
   parameter int unsigned NARROW_W = 16,
   localparam int unsigned VEC_W   = 2 * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             elem_size,
   input  logic [1:0]       mode,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   import vec_hsub_pkg::*;

   localparam int unsigned NLANE = 2;

   if (LANE_W % (4 * NARROW_W) != 0) begin : g_bad_lane
      $error("vec_hsub_unit: LANE_W must hold a whole number of broad pairs");
   end
   if (NARROW_W < 2) begin : g_bad_narrow
      $error("vec_hsub_unit: NARROW_W too small");
   end

   logic [NLANE-1:0][LANE_W-1:0] lane_res;
   logic [LANE_W-1:0]            hi_next;
   logic                         hi_load;

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      vec_hsub_lane #(.LANE_W(LANE_W), .NARROW_W(NARROW_W)) u_lane (
         .size_sel (elem_size),
         .lane_a   (src_a[l*LANE_W +: LANE_W]),
         .lane_b   (src_b[l*LANE_W +: LANE_W]),
         .lane_res (lane_res[l])
      );
   end

   always_comb begin
      hi_next = lane_res[1];
      hi_load = 1'b1;
      unique case (hs_mode_e'(mode))
         HS_KEEP_HI:  begin hi_next = lane_res[1]; hi_load = 1'b0; end
         HS_ZERO_HI:  begin hi_next = '0;          hi_load = 1'b1; end
         HS_WIDE:     begin hi_next = lane_res[1]; hi_load = 1'b1; end
         HS_WIDE_ALT: begin hi_next = lane_res[1]; hi_load = 1'b1; end
         default:     begin hi_next = lane_res[1]; hi_load = 1'b1; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result[LANE_W-1:0] <= lane_res[0];
            if (hi_load) begin
               result[VEC_W-1:LANE_W] <= hi_next;
            end
         end
      end
   end
endmodule

// File: rtl/vec_hsub_chk.sv
module vec_hsub_chk #(
   parameter int unsigned LANE_W   = 128,
   parameter int unsigned NARROW_W = 16,
   localparam int unsigned VEC_W   = 2 * LANE_W
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             elem_size,
   input logic [1:0]       mode,
   input logic [VEC_W-1:0] src_a,
   input logic [VEC_W-1:0] src_b,
   input logic             out_valid,
   input logic [VEC_W-1:0] result
);
   // R1
   low_minus_high_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !elem_size) |=>
         result[NARROW_W-1:0] ==
         $past(src_a[NARROW_W-1:0] - src_a[2*NARROW_W-1:NARROW_W]));

   // R5
   zero_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'b01) |=> result[VEC_W-1:LANE_W] == '0);

   // R6
   keep_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'b00) |=> $stable(result[VEC_W-1:LANE_W]));

   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(result)));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0));
endmodule

bind vec_hsub_unit vec_hsub_chk #(.LANE_W(LANE_W), .NARROW_W(NARROW_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .elem_size (elem_size),
   .mode      (mode),
   .src_a     (src_a),
   .src_b     (src_b),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/tb_vec_hsub_unit.sv
module tb_vec_hsub_unit;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         elem_size = 1'b0;
   logic [1:0]   mode = 2'b10;
   logic [255:0] src_a = '0;
   logic [255:0] src_b = '0;
   logic         out_valid;
   logic [255:0] result;

   int vectors = 0;
   int miscompares = 0;

   logic         m_valid = 1'b0;
   logic [255:0] m_res = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_hsub_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .elem_size(elem_size),
      .mode(mode), .src_a(src_a), .src_b(src_b),
      .out_valid(out_valid), .result(result)
   );

   // Behavioural reference for one 128-bit lane.
   function automatic logic [127:0] ref_lane(input logic [127:0] a, input logic [127:0] b,
                                             input logic sz);
      logic [127:0] r;
      int           d;
      longint       q;
      r = '0;
      if (!sz) begin
         for (int i = 0; i < 4; i++) begin
            d = int'(a[32*i +: 16]) - int'(a[32*i+16 +: 16]);
            r[16*i +: 16] = d[15:0];
            d = int'(b[32*i +: 16]) - int'(b[32*i+16 +: 16]);
            r[64+16*i +: 16] = d[15:0];
         end
      end else begin
         for (int i = 0; i < 2; i++) begin
            q = longint'(a[64*i +: 32]) - longint'(a[64*i+32 +: 32]);
            r[32*i +: 32] = q[31:0];
            q = longint'(b[64*i +: 32]) - longint'(b[64*i+32 +: 32]);
            r[64+32*i +: 32] = q[31:0];
         end
      end
      return r;
   endfunction

   task automatic step(input logic r, input logic v, input logic sz, input logic [1:0] md,
                       input logic [255:0] a, input logic [255:0] b, input string tag);
      logic         n_valid;
      logic [255:0] n_res;
      rst = r; in_valid = v; elem_size = sz; mode = md; src_a = a; src_b = b;
      n_res = m_res;
      if (r) begin
         n_valid = 1'b0; n_res = '0;
      end else if (v) begin
         n_valid = 1'b1;
         n_res[127:0] = ref_lane(a[127:0], b[127:0], sz);
         if (md == 2'b01)      n_res[255:128] = '0;
         else if (md != 2'b00) n_res[255:128] = ref_lane(a[255:128], b[255:128], sz);
      end else begin
         n_valid = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      m_valid = n_valid;
      m_res = n_res;
      vectors++;
      if (out_valid !== m_valid || result !== m_res) begin
         miscompares++;
         $display("FAIL %s: out_valid=%0b result=%h expected out_valid=%0b result=%h",
                  tag, out_valid, result, m_valid, m_res);
      end
   endtask

   function automatic logic [255:0] rnd256();
      logic [255:0] x;
      for (int k = 0; k < 8; k++) x[32*k +: 32] = $urandom;
      return x;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [255:0] a, b;
      @(negedge clk);
      // R10 reset state
      step(1, 0, 0, 2'b10, '0, '0, "R10");
      step(1, 0, 0, 2'b10, '0, '0, "R10");
      // R2 word pairs, ascending pattern
      for (int k = 0; k < 16; k++) begin
         a[16*k +: 16] = 16'(k * 3 + 1);
         b[16*k +: 16] = 16'(100 - k * 7);
      end
      step(0, 1, 0, 2'b10, a, b, "R2");
      // R3 dword pairs, same operands
      step(0, 1, 1, 2'b10, a, b, "R3");
      // R4 distinct upper lane
      a[255:128] = {8{16'h1234}} ^ 128'h00ff_0f0f_7777_8888_1111_2222_3333_4444;
      step(0, 1, 0, 2'b10, a, b, "R4");
      // R6 merge mode right after a full load: upper must persist
      step(0, 1, 0, 2'b00, rnd256(), rnd256(), "R6");
      step(0, 1, 1, 2'b00, rnd256(), rnd256(), "R6");
      // R5 zeroing
      step(0, 1, 1, 2'b01, rnd256(), rnd256(), "R5");
      // R7 wrap cases
      a = '0; b = '0;
      a[15:0] = 16'h0001; a[31:16] = 16'h8000;  // 0x0001 - 0x8000
      a[47:32] = 16'h8000; a[63:48] = 16'h0001; // 0x8000 - 0x0001 = 0x7FFF
      b[15:0] = 16'h7FFF; b[31:16] = 16'hFFFF;  // 0x7FFF - 0xFFFF = 0x8000
      step(0, 1, 0, 2'b10, a, b, "R7");
      a = '0; b = '0;
      a[31:0] = 32'h7FFF_FFFF; a[63:32] = 32'hFFFF_FFFF;
      b[31:0] = 32'h8000_0000; b[63:32] = 32'h0000_0001;
      a[159:128] = 32'h0; a[191:160] = 32'h8000_0000;
      step(0, 1, 1, 2'b10, a, b, "R7");
      // R9 idle cycles with changing inputs
      step(0, 0, 1, 2'b01, rnd256(), rnd256(), "R9");
      step(0, 0, 0, 2'b10, rnd256(), rnd256(), "R9");
      // R11 reserved mode as full width
      step(0, 1, 0, 2'b11, rnd256(), rnd256(), "R11");
      step(0, 1, 1, 2'b11, rnd256(), rnd256(), "R11");
      // R10 reset wins over capture
      step(1, 1, 0, 2'b10, rnd256(), rnd256(), "R10");
      // R8 back-to-back captures
      step(0, 1, 0, 2'b10, rnd256(), rnd256(), "R8");
      step(0, 1, 1, 2'b10, rnd256(), rnd256(), "R8");
      // R1 random mix of all controls
      for (int n = 0; n < 300; n++) begin
         step(($urandom % 40) == 0, ($urandom % 4) != 0, 1'($urandom), 2'($urandom),
              rnd256(), rnd256(), "R1");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule